// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block is the device (PHY) side of a two-wire station management bus that a host drives by toggling pins in software. The host provides the management clock, a data-out level and an output-enable flag. The responder brings all three into the system clock domain and acts on each rising edge of the management clock. It waits for a run of 32 driven ones, then decodes a clause-22 style header. A valid read shifts a 16-bit register out on the data-in line, and a valid write stores 16 bits into a local 32 x 16-bit register file.

A single down-counter places the events of a frame. It is loaded when the sampled history is all ones. The header is decoded when the counter reaches the midpoint. Read data is shifted out while the counter is below the midpoint, and a write is committed at zero. The responder answers any PHY address. Two identifier registers come out of reset with fixed values, and the remaining registers reset to zero.

Top module: `mdio_responder`

## Requirements
- R1: After reset, `mdi` is 0, register 2 reads 0x0022, register 3 reads 0x161A and every other register reads 0x0000.
- R2: On each rising edge of `mdc`, the sampled bit is `mdo AND mdoe`. A bit sent with `mdoe` low counts as 0, so it breaks a preamble run.
- R3: A frame is recognised only after 32 consecutive sampled ones; a longer run also works. The frame's first bit is the first sampled bit after the run. A run of 31 ones is not enough.
- R4: After synchronisation the frame carries, each field MSB first: start (2 bits), opcode (2), PHY address (5), register address (5), turnaround (2), data (16).
- R5: A write is accepted only when start = 01, opcode = 01 and turnaround = 10 (first bit 1, second bit 0). The 16 data bits then replace the addressed register once the 32nd frame bit is sampled.
- R6: A read is accepted when start = 01, opcode = 10 and the second turnaround bit samples as 0. The addressed register then appears on `mdi` MSB first, one bit after each rising `mdc` edge of frame bits 17 to 32.
- R7: A frame with any other start or opcode value stores nothing and does not change `mdi`.
- R8: The PHY address field is ignored; every address is answered.
- R9: `mdi` holds its last driven value whenever no read data is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the host (asynchronous) |
| mdo | input | 1 | Data level driven by the host |
| mdoe | input | 1 | Host output-enable; a sampled bit is 1 only while this is high |
| mdi | output | 1 | Read data returned to the host |

## Verification
Each rising `mdc` edge passes through SYNC_STAGES synchroniser flops and one edge-detect compare. So a read bit reaches `mdi` on the (SYNC_STAGES+1)-th system clock edge after the `mdc` transition, which is 3 cycles at the default setting. A commit lands in the register file at that same edge. The bench holds each `mdc` phase for five system cycles and reads `mdi` at the end of the high phase, after the update and before the next falling edge. Written values are observed only by a later read frame, which is many cycles past any commit.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  // Frame geometry (protocol constants)
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 16;
  localparam int DATA_BITS  = 16;
  localparam int REG_ADDR_W = 5;
  localparam int REG_COUNT  = 1 << REG_ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // Field positions inside the 16-bit header window
  localparam int START_LSB = 14;
  localparam int OP_LSB    = 12;
  localparam int REG_LSB   = 2;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WR      = 2'b01;
  localparam logic [1:0] OP_RD      = 2'b10;
  localparam logic [1:0] TA_WR      = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } mgmtState_t;

  typedef struct packed {
    logic                  loadRead;
    logic                  shiftOut;
    logic                  commit;
    logic [REG_ADDR_W-1:0] regAddr;
  } ctrlStrobes_t;

endpackage

// File: rtl/mdio_resp_ctrl.sv
module mdio_resp_ctrl
  import mdio_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mdcIn,
  input  logic                  mdoIn,
  input  logic                  mdoeIn,
  input  logic [FRAME_BITS-1:0] histNext,
  output logic                  sampleEdge,
  output logic                  sampleBit,
  output ctrlStrobes_t          strobes
);

  // Synchroniser chain for {mdc, mdo, mdoe}
  logic [2:0] syncPipe [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[g] <= '0;
          else       syncPipe[g] <= {mdcIn, mdoIn, mdoeIn};
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[g] <= '0;
          else       syncPipe[g] <= syncPipe[g-1];
        end
      end
    end
  endgenerate

  logic [2:0] syncOut;
  logic       prevMdc;

  assign syncOut    = syncPipe[SYNC_STAGES-1];
  assign sampleEdge = syncOut[2] & ~prevMdc;
  assign sampleBit  = syncOut[1] & syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMdc <= 1'b0;
    else       prevMdc <= syncOut[2];
  end

  // Frame position counter and state
  mgmtState_t             state, stateNext;
  logic [CNT_W-1:0]       cnt, cntNext, cntEff;
  logic [REG_ADDR_W-1:0]  regAddrQ;
  logic                   syncHit, atDecode, writeOk, readOk;
  logic [1:0]             fStart, fOp, fTa;
  logic [REG_ADDR_W-1:0]  fReg;

  assign syncHit  = &histNext;
  assign cntEff   = syncHit ? CNT_W'(FRAME_BITS) : cnt;
  assign fStart   = histNext[START_LSB +: 2];
  assign fOp      = histNext[OP_LSB +: 2];
  assign fReg     = histNext[REG_LSB +: REG_ADDR_W];
  assign fTa      = histNext[1:0];
  assign writeOk  = (fStart == START_CODE) && (fOp == OP_WR) && (fTa == TA_WR);
  assign readOk   = (fStart == START_CODE) && (fOp == OP_RD) && !fTa[0];
  assign atDecode = sampleEdge && (cntEff == CNT_W'(HDR_BITS));

  assign strobes.loadRead = atDecode && readOk;
  assign strobes.shiftOut = sampleEdge && (state == ST_READ) && (cntEff < CNT_W'(HDR_BITS));
  assign strobes.commit   = sampleEdge && (state == ST_WRITE) && (cntEff == '0);
  assign strobes.regAddr  = atDecode ? fReg : regAddrQ;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    if (sampleEdge) begin
      cntNext = (cntEff == '0) ? '0 : cntEff - 1'b1;
      if (atDecode) begin
        if (writeOk)     stateNext = ST_WRITE;
        else if (readOk) stateNext = ST_READ;
        else             stateNext = ST_IDLE;
      end else if (cntEff == '0) begin
        stateNext = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      regAddrQ <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (atDecode) regAddrQ <= fReg;
    end
  end

  // R6: read shifting happens only in the lower half of the frame
  a_r6_read_window: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |-> (cnt < CNT_W'(HDR_BITS)));

  // R5: a commit always ends the write and returns to idle
  a_r5_commit_ends: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (state == ST_IDLE));

  // R4: decode, shift and commit never coincide
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadRead, strobes.shiftOut, strobes.commit}));

  // R3: a full run of ones restarts the frame count
  a_r3_sync_reload: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEdge && syncHit) |=> (cnt == CNT_W'(FRAME_BITS - 1)));

endmodule

// File: rtl/mdio_resp_dp.sv
module mdio_resp_dp
  import mdio_resp_pkg::*;
#(
  parameter int              ID_REG_A = 2,
  parameter logic [DATA_BITS-1:0] ID_VAL_A = 16'h0022,
  parameter int              ID_REG_B = 3,
  parameter logic [DATA_BITS-1:0] ID_VAL_B = 16'h161A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleEdge,
  input  logic                  sampleBit,
  input  ctrlStrobes_t          strobes,
  output logic [FRAME_BITS-1:0] histNext,
  output logic                  mdi
);

  // Bit history: 31 stored bits plus the bit being sampled
  logic [FRAME_BITS-2:0] histQ;

  assign histNext = {histQ, sampleBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           histQ <= '0;
    else if (sampleEdge) histQ <= histNext[FRAME_BITS-2:0];
  end

  // Register file
  logic [DATA_BITS-1:0] regs [REG_COUNT];

  generate
    for (genvar i = 0; i < REG_COUNT; i++) begin : gReg
      localparam logic [DATA_BITS-1:0] RST_VAL =
        (i == ID_REG_A) ? ID_VAL_A :
        (i == ID_REG_B) ? ID_VAL_B : '0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regs[i] <= RST_VAL;
        else if (strobes.commit && (strobes.regAddr == REG_ADDR_W'(i)))
          regs[i] <= histNext[DATA_BITS-1:0];
      end
    end
  endgenerate

  // Read shifter
  logic [DATA_BITS-1:0] readShift;
  logic                 mdiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readShift <= '0;
      mdiQ      <= 1'b0;
    end else if (strobes.loadRead) begin
      readShift <= regs[strobes.regAddr];
    end else if (strobes.shiftOut) begin
      mdiQ      <= readShift[DATA_BITS-1];
      readShift <= {readShift[DATA_BITS-2:0], 1'b0};
    end
  end

  assign mdi = mdiQ;

  // R9: mdi moves only on a shift strobe from the control
  a_r9_mdi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftOut |=> $stable(mdi));

  // R5: a commit lands the sampled data word in the addressed entry
  a_r5_commit_data: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (regs[$past(strobes.regAddr)] == $past(histNext[DATA_BITS-1:0])));

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
  import mdio_resp_pkg::*;
#(
  parameter int                   SYNC_STAGES = 2,
  parameter int                   ID_REG_A    = 2,
  parameter logic [DATA_BITS-1:0] ID_VAL_A    = 16'h0022,
  parameter int                   ID_REG_B    = 3,
  parameter logic [DATA_BITS-1:0] ID_VAL_B    = 16'h161A
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdc,
  input  logic mdo,
  input  logic mdoe,
  output logic mdi
);

  logic                  sampleEdge;
  logic                  sampleBit;
  logic [FRAME_BITS-1:0] histNext;
  ctrlStrobes_t          strobes;

  mdio_resp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .mdcIn     (mdc),
    .mdoIn     (mdo),
    .mdoeIn    (mdoe),
    .histNext  (histNext),
    .sampleEdge(sampleEdge),
    .sampleBit (sampleBit),
    .strobes   (strobes)
  );

  mdio_resp_dp #(
    .ID_REG_A(ID_REG_A),
    .ID_VAL_A(ID_VAL_A),
    .ID_REG_B(ID_REG_B),
    .ID_VAL_B(ID_VAL_B)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleEdge(sampleEdge),
    .sampleBit (sampleBit),
    .strobes   (strobes),
    .histNext  (histNext),
    .mdi       (mdi)
  );

endmodule

// File: tb/tb_mdio_responder.sv
module tb_mdio_responder;

  localparam int HALF = 5;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic mdo = 1'b0;
  logic mdoe = 1'b0;
  logic mdi;

  int vectors = 0;
  int miscompares = 0;

  logic [15:0] model [32];
  logic        lastMdi = 1'b0;

  always #2 clk = ~clk;

  mdio_responder dut (
    .clk (clk),
    .rstN(rstN),
    .mdc (mdc),
    .mdo (mdo),
    .mdoe(mdoe),
    .mdi (mdi)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One management clock period; returns mdi at the end of the high phase
  task automatic mdioBit(input logic b, input logic oe, output logic s);
    @(negedge clk);
    mdc = 1'b0; mdo = b; mdoe = oe;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    s = mdi;
  endtask

  function automatic bit writeAccepted(logic [1:0] st, logic [1:0] op, logic [1:0] ta);
    return (st == 2'b01) && (op == 2'b01) && (ta == 2'b10);
  endfunction

  function automatic bit readAccepted(logic [1:0] st, logic [1:0] op, logic [1:0] ta);
    return (st == 2'b01) && (op == 2'b10) && (ta[0] == 1'b0);
  endfunction

  // Full frame with expectation from the requirement model
  task automatic applyFrame(input string tag, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input logic [1:0] ta, input logic taOe,
                            input logic [15:0] data, input logic dataOe,
                            input int preN, input int dropAt);
    logic s;
    logic [15:0] got;
    logic [15:0] exp;
    logic [13:0] hdr;
    logic [1:0]  taEff;
    bit synced;
    got = '0;
    hdr = {st, op, phy, ra};
    taEff = taOe ? ta : 2'b00;
    synced = (preN >= 32) && ((dropAt < 0) || (dropAt < preN - 32));
    for (int i = 0; i < 4; i++) mdioBit(1'b0, 1'b0, s);
    for (int i = 0; i < preN; i++) mdioBit(1'b1, (i != dropAt), s);
    for (int i = 13; i >= 0; i--) mdioBit(hdr[i], 1'b1, s);
    mdioBit(ta[1], taOe, s);
    mdioBit(ta[0], taOe, s);
    for (int i = 15; i >= 0; i--) begin
      mdioBit(data[i], dataOe, s);
      got = {got[14:0], s};
    end
    if (synced && readAccepted(st, op, taEff)) begin
      exp = model[ra];
      lastMdi = model[ra][0];
    end else begin
      exp = {16{lastMdi}};
    end
    check(tag, got, exp);
    if (synced && writeAccepted(st, op, taEff))
      model[ra] = dataOe ? data : 16'h0000;
  endtask

  task automatic rd(input string tag, input logic [4:0] ra);
    applyFrame(tag, 2'b01, 2'b10, 5'd1, ra, 2'b00, 1'b0, 16'h0000, 1'b0, 32, -1);
  endtask

  task automatic wr(input string tag, input logic [4:0] ra, input logic [15:0] d);
    applyFrame(tag, 2'b01, 2'b01, 5'd1, ra, 2'b10, 1'b1, d, 1'b1, 32, -1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    model[2] = 16'h0022;
    model[3] = 16'h161A;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1 mdi after reset", {15'd0, mdi}, 16'h0000);
    rd("R1 id reg 2", 5'd2);
    rd("R1 id reg 3", 5'd3);
    rd("R1 reg 0", 5'd0);
    rd("R1 reg 31", 5'd31);

    // R5: write and readback
    wr("R5 write reg 5", 5'd5, 16'hA5C3);
    rd("R5 readback reg 5", 5'd5);

    // R4: distinct addresses keep their own data
    wr("R4 write reg 30", 5'd30, 16'h8001);
    wr("R4 write reg 1", 5'd1, 16'h7FFE);
    rd("R4 readback reg 30", 5'd30);
    rd("R4 readback reg 1", 5'd1);

    // R8: PHY address ignored
    applyFrame("R8 write phy 17", 2'b01, 2'b01, 5'd17, 5'd9, 2'b10, 1'b1, 16'h3C3C, 1'b1, 32, -1);
    applyFrame("R8 read phy 3", 2'b01, 2'b10, 5'd3, 5'd9, 2'b00, 1'b0, 16'h0, 1'b0, 32, -1);

    // R7: bad start and opcode leave registers and mdi alone
    applyFrame("R7 bad start write", 2'b00, 2'b01, 5'd1, 5'd5, 2'b10, 1'b1, 16'h1111, 1'b1, 32, -1);
    applyFrame("R7 bad opcode 11", 2'b01, 2'b11, 5'd1, 5'd5, 2'b10, 1'b1, 16'h2222, 1'b1, 32, -1);
    applyFrame("R7 bad opcode 00", 2'b01, 2'b00, 5'd1, 5'd5, 2'b10, 1'b1, 16'h3333, 1'b1, 32, -1);
    applyFrame("R7 bad start read", 2'b11, 2'b10, 5'd1, 5'd2, 2'b00, 1'b0, 16'h0, 1'b0, 32, -1);
    rd("R7 reg 5 unchanged", 5'd5);

    // R5: wrong turnaround rejects a write
    applyFrame("R5 write ta 11", 2'b01, 2'b01, 5'd1, 5'd5, 2'b11, 1'b1, 16'h4444, 1'b1, 32, -1);
    rd("R5 reg 5 after bad ta", 5'd5);

    // R6: read turnaround only needs the second bit low
    applyFrame("R6 read ta driven 10", 2'b01, 2'b10, 5'd1, 5'd30, 2'b10, 1'b1, 16'h0, 1'b0, 32, -1);
    applyFrame("R6 read ta driven 01", 2'b01, 2'b10, 5'd1, 5'd3, 2'b01, 1'b1, 16'h0, 1'b0, 32, -1);

    // R2: oe low inside the preamble breaks the run
    applyFrame("R2 preamble oe gap", 2'b01, 2'b01, 5'd1, 5'd7, 2'b10, 1'b1, 16'hBEEF, 1'b1, 32, 10);
    rd("R2 reg 7 untouched", 5'd7);
    applyFrame("R2 early gap long run", 2'b01, 2'b01, 5'd1, 5'd7, 2'b10, 1'b1, 16'hCAFE, 1'b1, 36, 2);
    rd("R2 reg 7 written", 5'd7);

    // R3: preamble length
    applyFrame("R3 preamble 31", 2'b01, 2'b01, 5'd1, 5'd8, 2'b10, 1'b1, 16'h1234, 1'b1, 31, -1);
    rd("R3 reg 8 untouched", 5'd8);
    applyFrame("R3 preamble 40", 2'b01, 2'b01, 5'd1, 5'd8, 2'b10, 1'b1, 16'h5678, 1'b1, 40, -1);
    rd("R3 reg 8 written", 5'd8);

    // R9: mdi holds through a write after a read ending in 1
    wr("R9 setup reg 12", 5'd12, 16'h0001);
    rd("R9 read odd", 5'd12);
    wr("R9 hold during write", 5'd13, 16'hFFFE);
    check("R9 mdi idle hold", {15'd0, mdi}, {15'd0, lastMdi});

    // Random mix
    for (int n = 0; n < 50; n++) begin
      int kind;
      logic [4:0] ra;
      logic [4:0] phy;
      logic [15:0] d;
      logic [1:0] st;
      logic [1:0] op;
      kind = int'($urandom % 4);
      ra = 5'($urandom);
      phy = 5'($urandom);
      d = 16'($urandom);
      case (kind)
        0: applyFrame("random R5 write", 2'b01, 2'b01, phy, ra, 2'b10, 1'b1, d, 1'b1, 32, -1);
        1: applyFrame("random R6 read", 2'b01, 2'b10, phy, ra, 2'b00, 1'b0, 16'h0, 1'b0, 32, -1);
        2: begin
          st = 2'($urandom % 3);
          if (st == 2'b01) st = 2'b11;
          applyFrame("random R7 bad start", st, 2'($urandom), phy, ra, 2'b10, 1'b1, d, 1'b1, 32, -1);
        end
        default: begin
          op = ($urandom % 2 == 0) ? 2'b00 : 2'b11;
          applyFrame("random R7 bad op", 2'b01, op, phy, ra, 2'b10, 1'b1, d, 1'b1, 32, -1);
        end
      endcase
    end
    for (int i = 0; i < 32; i++) rd("final R5 sweep", 5'(i));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule